// File: doc/BRIEF.md
# Bidirectional Strobed Byte Port

This block moves bytes across a parallel pin interface. It uses two control wires: an active-low "data available" strobe and an active-high "ready" line. The port works in one of two directions. In receive mode an outside source drives the byte and the strobe. The port answers on the ready line and captures the byte for the CPU. In send mode the port drives the byte and the strobe, and an outside sink answers on the ready line.

Both directions follow a four-phase interlock. The side that owns the data lowers the strobe. The other side lowers ready. The strobe then returns high, and ready rises again before the next byte. Both control inputs pass through two-flop synchronisers before the port acts on them. In receive mode, ready rises only after the CPU has taken the captured byte, so a slow CPU throttles the source. A direction request takes effect only between transfers. Pin tristating is given as separate output-enable signals, one per pin group.

Top module: `strobe_port`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `rdy_out` and `dav_n_out` are 1, `cpu_rd_valid` and `cpu_wr_ack` are 0, and `dir_out` is 0 (receive mode).
- R2: When `dir_out` is 0, `rdy_oe` is 1 and `dav_oe` and `pin_data_oe` are 0. When `dir_out` is 1, `dav_oe` and `pin_data_oe` are 1 and `rdy_oe` is 0. `dav_oe` and `rdy_oe` are never high together.
- R3: In receive mode, when `dav_n_in` falls from idle, `rdy_out` falls and `cpu_rd_valid` rises on the third rising clock edge after the change.
- R4: In receive mode, `rdy_out` stays low until both of these have happened: the CPU has pulsed `cpu_rd_ack` while `cpu_rd_valid` is 1, and the synchronised `dav_n_in` is high. `rdy_out` then rises on the edge after the later of the two. A read clears `cpu_rd_valid` on the edge it is sampled.
- R5: `cpu_rd_data` holds the byte present on `pin_data_in` at the edge where `rdy_out` fell. It does not follow later changes on the pins.
- R6: In send mode, a write (`cpu_wr_valid` high) is accepted only while the sender is idle. Acceptance raises `cpu_wr_ack` for exactly one cycle and puts the byte on `pin_data_out` on the same edge. `dav_n_out` falls `SETUP_CYCLES` edges later.
- R7: In send mode, `dav_n_out` stays low until the synchronised `rdy_in` is low, and rises on the third edge after `rdy_in` falls. `pin_data_out` does not change while `dav_n_out` is low.
- R8: After a send completes, no new write is accepted and `dav_n_out` stays high until the synchronised `rdy_in` has risen again.
- R9: A change of `dir_req` takes effect on `dir_out` only while both control outputs are idle high and no transfer is in progress. A request made during a transfer is held until that transfer completes.
- R10: In send mode, `dav_n_in` has no effect: `rdy_out` stays 1 and `cpu_rd_valid` stays 0. In receive mode, `cpu_wr_valid` has no effect: no ack is given and `dav_n_out` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_req | input | 1 | Requested direction: 0 receive, 1 send |
| dir_out | output | 1 | Direction in force |
| cpu_wr_valid | input | 1 | CPU offers a byte to send |
| cpu_wr_data | input | WIDTH | Byte to send |
| cpu_wr_ack | output | 1 | One-cycle pulse: byte accepted |
| cpu_rd_valid | output | 1 | A received byte is waiting |
| cpu_rd_data | output | WIDTH | Received byte |
| cpu_rd_ack | input | 1 | CPU takes the waiting byte |
| pin_data_in | input | WIDTH | Data pins as seen from outside |
| pin_data_out | output | WIDTH | Data pins driven in send mode |
| pin_data_oe | output | 1 | Enable for the data pin drivers |
| dav_n_in | input | 1 | Strobe pin as seen from outside, active low |
| dav_n_out | output | 1 | Strobe driven in send mode, active low |
| dav_oe | output | 1 | Enable for the strobe pin driver |
| rdy_in | input | 1 | Ready pin as seen from outside |
| rdy_out | output | 1 | Ready driven in receive mode |
| rdy_oe | output | 1 | Enable for the ready pin driver |

## Verification
The assertions assume that the outside parties obey the interlock. A source keeps the data pins steady from the strobe falling until ready falls. It raises the strobe only after ready is low. A sink lowers ready only while the strobe is low and raises it only after the strobe has returned high. The data pins themselves are not synchronised, so the stability rule for the source is taken on trust. The bench's source and sink tasks change pin levels only at falling clock edges, and only after seeing the answer they wait for. Tests that show an input has no effect drive the pins only in the mode where those pins are unused.

// File: rtl/hsp_pkg.sv
package hsp_pkg;
  typedef enum logic {DIR_IN = 1'b0, DIR_OUT = 1'b1} dir_e;
  typedef enum logic {RX_IDLE = 1'b0, RX_HELD = 1'b1} rx_state_e;
  typedef enum logic [1:0] {
    TX_IDLE   = 2'd0,
    TX_SETUP  = 2'd1,
    TX_WAIT_A = 2'd2,
    TX_WAIT_R = 2'd3
  } tx_state_e;
endpackage

// File: rtl/hsp_sync.sv
module hsp_sync #(
  parameter int WIDTH = 1,
  parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : g_bit
      logic stage1, stage2;
      always_ff @(posedge clk) begin
        if (rst) begin
          stage1 <= RESET_VAL[b];
          stage2 <= RESET_VAL[b];
        end else begin
          stage1 <= d[b];
          stage2 <= stage1;
        end
      end
      assign q[b] = stage2;
    end
  endgenerate
endmodule

// File: rtl/hsp_rx.sv
module hsp_rx
  import hsp_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             dav_n_s,
  input  logic [WIDTH-1:0] pin_data,
  input  logic             rd_ack,
  output logic             rd_valid,
  output logic [WIDTH-1:0] rd_data,
  output logic             rdy_out,
  output logic             idle
);
  rx_state_e state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= RX_IDLE;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rdy_out  <= 1'b1;
    end else begin
      unique case (state)
        RX_IDLE: begin
          if (en && !dav_n_s) begin
            rd_data  <= pin_data;
            rd_valid <= 1'b1;
            rdy_out  <= 1'b0;
            state    <= RX_HELD;
          end
        end
        RX_HELD: begin
          if (rd_ack && rd_valid) rd_valid <= 1'b0;
          if (!rd_valid && dav_n_s) begin
            rdy_out <= 1'b1;
            state   <= RX_IDLE;
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  assign idle = (state == RX_IDLE) && dav_n_s;
endmodule

// File: rtl/hsp_tx.sv
module hsp_tx
  import hsp_pkg::*;
#(
  parameter int WIDTH        = 8,
  parameter int SETUP_CYCLES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             rdy_s,
  input  logic             wr_valid,
  input  logic [WIDTH-1:0] wr_data,
  output logic             wr_ack,
  output logic [WIDTH-1:0] data_out,
  output logic             dav_n_out,
  output logic             idle
);
  localparam int EFF_SETUP = (SETUP_CYCLES < 1) ? 1 : SETUP_CYCLES;
  localparam int CW        = (EFF_SETUP < 2) ? 1 : $clog2(EFF_SETUP);
  localparam logic [CW-1:0] LAST = CW'(EFF_SETUP - 1);

  tx_state_e     state;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= TX_IDLE;
      cnt       <= '0;
      wr_ack    <= 1'b0;
      data_out  <= '0;
      dav_n_out <= 1'b1;
    end else begin
      wr_ack <= 1'b0;
      unique case (state)
        TX_IDLE: begin
          if (en && wr_valid) begin
            data_out <= wr_data;
            wr_ack   <= 1'b1;
            cnt      <= '0;
            state    <= TX_SETUP;
          end
        end
        TX_SETUP: begin
          if (cnt == LAST) begin
            dav_n_out <= 1'b0;
            state     <= TX_WAIT_A;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        TX_WAIT_A: begin
          if (!rdy_s) begin
            dav_n_out <= 1'b1;
            state     <= TX_WAIT_R;
          end
        end
        TX_WAIT_R: begin
          if (rdy_s) state <= TX_IDLE;
        end
        default: state <= TX_IDLE;
      endcase
    end
  end

  assign idle = (state == TX_IDLE);
endmodule

// File: rtl/hsp_dir.sv
module hsp_dir
  import hsp_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic rx_idle,
  input  logic tx_idle,
  input  logic wr_valid,
  output logic dir_q,
  output logic data_oe,
  output logic dav_oe,
  output logic rdy_oe
);
  logic dir_nxt;
  logic may_switch;

  always_comb begin
    may_switch = rx_idle && tx_idle && !((dir_q == DIR_OUT) && wr_valid);
    dir_nxt    = (may_switch && (req != dir_q)) ? req : dir_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q   <= DIR_IN;
      data_oe <= 1'b0;
      dav_oe  <= 1'b0;
      rdy_oe  <= 1'b1;
    end else begin
      dir_q   <= dir_nxt;
      data_oe <= (dir_nxt == DIR_OUT);
      dav_oe  <= (dir_nxt == DIR_OUT);
      rdy_oe  <= (dir_nxt == DIR_IN);
    end
  end
endmodule

// File: rtl/strobe_port.sv
module strobe_port
  import hsp_pkg::*;
#(
  parameter int WIDTH        = 8,
  parameter int SETUP_CYCLES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dir_req,
  output logic             dir_out,
  input  logic             cpu_wr_valid,
  input  logic [WIDTH-1:0] cpu_wr_data,
  output logic             cpu_wr_ack,
  output logic             cpu_rd_valid,
  output logic [WIDTH-1:0] cpu_rd_data,
  input  logic             cpu_rd_ack,
  input  logic [WIDTH-1:0] pin_data_in,
  output logic [WIDTH-1:0] pin_data_out,
  output logic             pin_data_oe,
  input  logic             dav_n_in,
  output logic             dav_n_out,
  output logic             dav_oe,
  input  logic             rdy_in,
  output logic             rdy_out,
  output logic             rdy_oe
);
  logic [1:0] ctl_raw, ctl_s;
  logic       dav_n_s, rdy_s;
  logic       rx_idle, tx_idle;
  logic       dir_q;

  assign ctl_raw = {rdy_in, dav_n_in};

  hsp_sync #(.WIDTH(2), .RESET_VAL(2'b11)) u_sync (
    .clk(clk), .rst(rst), .d(ctl_raw), .q(ctl_s)
  );
  assign dav_n_s = ctl_s[0];
  assign rdy_s   = ctl_s[1];

  hsp_rx #(.WIDTH(WIDTH)) u_rx (
    .clk(clk), .rst(rst), .en(dir_q == DIR_IN),
    .dav_n_s(dav_n_s), .pin_data(pin_data_in), .rd_ack(cpu_rd_ack),
    .rd_valid(cpu_rd_valid), .rd_data(cpu_rd_data),
    .rdy_out(rdy_out), .idle(rx_idle)
  );

  hsp_tx #(.WIDTH(WIDTH), .SETUP_CYCLES(SETUP_CYCLES)) u_tx (
    .clk(clk), .rst(rst), .en(dir_q == DIR_OUT),
    .rdy_s(rdy_s), .wr_valid(cpu_wr_valid), .wr_data(cpu_wr_data),
    .wr_ack(cpu_wr_ack), .data_out(pin_data_out),
    .dav_n_out(dav_n_out), .idle(tx_idle)
  );

  hsp_dir u_dir (
    .clk(clk), .rst(rst), .req(dir_req),
    .rx_idle(rx_idle), .tx_idle(tx_idle), .wr_valid(cpu_wr_valid),
    .dir_q(dir_q), .data_oe(pin_data_oe), .dav_oe(dav_oe), .rdy_oe(rdy_oe)
  );

  assign dir_out = dir_q;
endmodule

// File: rtl/strobe_port_chk.sv
module strobe_port_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             dir_out,
  input logic             cpu_wr_ack,
  input logic             cpu_rd_valid,
  input logic [WIDTH-1:0] pin_data_out,
  input logic             pin_data_oe,
  input logic             dav_n_out,
  input logic             dav_oe,
  input logic             rdy_out,
  input logic             rdy_oe
);
  assert_oe_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
    !(dav_oe && rdy_oe));

  assert_rdy_fall_has_byte_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(rdy_out) |-> cpu_rd_valid);

  assert_rdy_rise_after_read_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(rdy_out) |-> !cpu_rd_valid);

  assert_ack_single_R6: assert property (@(posedge clk) disable iff (rst)
    cpu_wr_ack |=> !cpu_wr_ack);

  assert_strobe_needs_bus_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(dav_n_out) |-> pin_data_oe);

  assert_data_stable_R7: assert property (@(posedge clk) disable iff (rst)
    (!dav_n_out && $past(!dav_n_out)) |-> $stable(pin_data_out));

  assert_dir_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !$stable(dir_out) |-> ($past(dav_n_out) && $past(rdy_out)));

  assert_no_ack_receive_R10: assert property (@(posedge clk) disable iff (rst)
    cpu_wr_ack |-> dir_out);
endmodule

bind strobe_port strobe_port_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .dir_out(dir_out), .cpu_wr_ack(cpu_wr_ack),
  .cpu_rd_valid(cpu_rd_valid), .pin_data_out(pin_data_out),
  .pin_data_oe(pin_data_oe), .dav_n_out(dav_n_out), .dav_oe(dav_oe),
  .rdy_out(rdy_out), .rdy_oe(rdy_oe)
);

// File: tb/strobe_port_tb_top.sv
module strobe_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 8;
  localparam int SETUP      = 2;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         dir_req = 1'b0;
  logic         dir_out;
  logic         cpu_wr_valid = 1'b0;
  logic [W-1:0] cpu_wr_data = '0;
  logic         cpu_wr_ack;
  logic         cpu_rd_valid;
  logic [W-1:0] cpu_rd_data;
  logic         cpu_rd_ack = 1'b0;
  logic [W-1:0] pin_data_in = '0;
  logic [W-1:0] pin_data_out;
  logic         pin_data_oe;
  logic         dav_n_in = 1'b1;
  logic         dav_n_out;
  logic         dav_oe;
  logic         rdy_in = 1'b1;
  logic         rdy_out;
  logic         rdy_oe;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strobe_port #(.WIDTH(W), .SETUP_CYCLES(SETUP)) dut_i (
    .clk(clk), .rst(rst), .dir_req(dir_req), .dir_out(dir_out),
    .cpu_wr_valid(cpu_wr_valid), .cpu_wr_data(cpu_wr_data), .cpu_wr_ack(cpu_wr_ack),
    .cpu_rd_valid(cpu_rd_valid), .cpu_rd_data(cpu_rd_data), .cpu_rd_ack(cpu_rd_ack),
    .pin_data_in(pin_data_in), .pin_data_out(pin_data_out), .pin_data_oe(pin_data_oe),
    .dav_n_in(dav_n_in), .dav_n_out(dav_n_out), .dav_oe(dav_oe),
    .rdy_in(rdy_in), .rdy_out(rdy_out), .rdy_oe(rdy_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Poll a condition at falling edges; returns 1 if seen within limit.
  task automatic wait_rdy(input logic lvl, input int lim, output logic ok);
    ok = 1'b0;
    for (int i = 0; i < lim; i++) begin
      if (rdy_out === lvl) begin ok = 1'b1; break; end
      step(1);
    end
  endtask

  task automatic wait_dav(input logic lvl, input int lim, output logic ok);
    ok = 1'b0;
    for (int i = 0; i < lim; i++) begin
      if (dav_n_out === lvl) begin ok = 1'b1; break; end
      step(1);
    end
  endtask

  task automatic wait_dir(input logic lvl, input int lim, output logic ok);
    ok = 1'b0;
    for (int i = 0; i < lim; i++) begin
      if (dir_out === lvl) begin ok = 1'b1; break; end
      step(1);
    end
  endtask

  task automatic cpu_read();
    cpu_rd_ack = 1'b1;
    step(1);
    cpu_rd_ack = 1'b0;
  endtask

  // Sink side: wait strobe low, answer, wait strobe high, release.
  task automatic sink_cycle(input logic [W-1:0] exp_byte, input string req);
    logic ok;
    wait_dav(1'b0, 20, ok);
    chk(req, ok, 1);
    chk(req, pin_data_out, exp_byte);
    rdy_in = 1'b0;
    wait_dav(1'b1, 20, ok);
    chk(req, ok, 1);
    rdy_in = 1'b1;
    step(4);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    step(3);
    chk("R1 rdy", rdy_out, 1);
    chk("R1 dav", dav_n_out, 1);
    chk("R1 valid", cpu_rd_valid, 0);
    chk("R1 ack", cpu_wr_ack, 0);
    chk("R1 dir", dir_out, 0);
    rst = 1'b0;
    step(1);
    chk("R1 dir after", dir_out, 0);
    chk("R2 rx oe", {rdy_oe, dav_oe, pin_data_oe}, 3'b100);
  endtask

  task automatic t_rx_latency();
    pin_data_in = 8'hA5;
    dav_n_in    = 1'b0;
    step(2);
    chk("R3 rdy before", rdy_out, 1);
    step(1);
    chk("R3 rdy low", rdy_out, 0);
    chk("R3 valid", cpu_rd_valid, 1);
    chk("R5 data", cpu_rd_data, 8'hA5);
    pin_data_in = 8'h00;
    dav_n_in    = 1'b1;
    step(6);
    chk("R4 held unread", rdy_out, 0);
    chk("R5 data holds", cpu_rd_data, 8'hA5);
    cpu_read();
    chk("R4 valid cleared", cpu_rd_valid, 0);
    chk("R4 rdy one edge later", rdy_out, 0);
    step(1);
    chk("R4 rdy up", rdy_out, 1);
  endtask

  task automatic t_rx_read_first();
    logic ok;
    pin_data_in = 8'h3E;
    dav_n_in    = 1'b0;
    wait_rdy(1'b0, 10, ok);
    chk("R3 second byte", ok, 1);
    chk("R5 second data", cpu_rd_data, 8'h3E);
    cpu_read();
    step(4);
    chk("R4 waits strobe", rdy_out, 0);
    dav_n_in = 1'b1;
    step(2);
    chk("R4 sync delay", rdy_out, 0);
    step(1);
    chk("R4 rdy after strobe", rdy_out, 1);
    step(2);
  endtask

  task automatic t_rx_ignores_write();
    cpu_wr_valid = 1'b1;
    cpu_wr_data  = 8'h99;
    for (int i = 0; i < 5; i++) begin
      step(1);
      if (cpu_wr_ack !== 1'b0 || dav_n_out !== 1'b1) begin
        chk("R10 write ignored", {cpu_wr_ack, dav_n_out}, 2'b01);
      end
    end
    cpu_wr_valid = 1'b0;
    chk("R10 no strobe", dav_n_out, 1);
  endtask

  task automatic t_to_send();
    logic ok;
    dir_req = 1'b1;
    wait_dir(1'b1, 10, ok);
    chk("R9 switch idle", ok, 1);
    step(1);
    chk("R2 tx oe", {rdy_oe, dav_oe, pin_data_oe}, 3'b011);
  endtask

  task automatic t_tx_setup();
    cpu_wr_valid = 1'b1;
    cpu_wr_data  = 8'h3C;
    step(1);
    cpu_wr_valid = 1'b0;
    chk("R6 ack", cpu_wr_ack, 1);
    chk("R6 bus", pin_data_out, 8'h3C);
    chk("R6 strobe high", dav_n_out, 1);
    step(1);
    chk("R6 ack single", cpu_wr_ack, 0);
    step(SETUP - 1);
    chk("R6 strobe low", dav_n_out, 0);
    step(5);
    chk("R7 holds without ready", dav_n_out, 0);
    chk("R7 bus stable", pin_data_out, 8'h3C);
    rdy_in = 1'b0;
    step(2);
    chk("R7 sync delay", dav_n_out, 0);
    step(1);
    chk("R7 strobe released", dav_n_out, 1);
  endtask

  task automatic t_tx_wait_ready();
    logic seen;
    cpu_wr_valid = 1'b1;
    cpu_wr_data  = 8'h77;
    seen = 1'b0;
    for (int i = 0; i < 6; i++) begin
      step(1);
      if (cpu_wr_ack === 1'b1 || dav_n_out !== 1'b1) seen = 1'b1;
    end
    chk("R8 blocked while ready low", seen, 0);
    rdy_in = 1'b1;
    seen = 1'b0;
    for (int i = 0; i < 8; i++) begin
      step(1);
      if (cpu_wr_ack === 1'b1) begin seen = 1'b1; break; end
    end
    cpu_wr_valid = 1'b0;
    chk("R8 accepted after ready", seen, 1);
    sink_cycle(8'h77, "R7 second send");
  endtask

  task automatic t_tx_ignores_strobe();
    dav_n_in = 1'b0;
    step(6);
    chk("R10 rdy unmoved", rdy_out, 1);
    chk("R10 no byte", cpu_rd_valid, 0);
    dav_n_in = 1'b1;
    step(3);
  endtask

  task automatic t_defer_from_send();
    logic ok;
    cpu_wr_valid = 1'b1;
    cpu_wr_data  = 8'h5A;
    step(1);
    cpu_wr_valid = 1'b0;
    wait_dav(1'b0, 10, ok);
    dir_req = 1'b0;
    step(6);
    chk("R9 held in send", dir_out, 1);
    rdy_in = 1'b0;
    wait_dav(1'b1, 10, ok);
    step(3);
    chk("R9 held until ready high", dir_out, 1);
    rdy_in = 1'b1;
    wait_dir(1'b0, 12, ok);
    chk("R9 switched after send", ok, 1);
    step(1);
    chk("R2 back to rx oe", {rdy_oe, dav_oe, pin_data_oe}, 3'b100);
  endtask

  task automatic t_defer_from_receive();
    logic ok;
    pin_data_in = 8'hC3;
    dav_n_in    = 1'b0;
    wait_rdy(1'b0, 10, ok);
    dir_req = 1'b1;
    dav_n_in = 1'b1;
    step(6);
    chk("R9 held in receive", dir_out, 0);
    chk("R5 third data", cpu_rd_data, 8'hC3);
    cpu_read();
    wait_dir(1'b1, 10, ok);
    chk("R9 switched after receive", ok, 1);
    chk("R4 rdy restored", rdy_out, 1);
  endtask

  initial begin
    step(1);
    t_reset();
    t_rx_latency();
    t_rx_read_first();
    t_rx_ignores_write();
    t_to_send();
    t_tx_setup();
    t_tx_wait_ready();
    t_tx_ignores_strobe();
    t_defer_from_send();
    t_defer_from_receive();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule